// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory shared by several processor ports and decides whether a store-exclusive may reach the memory. Each port owns one reservation: a valid bit and a word tag. A load-exclusive from a port arms that port's reservation for the accessed word. A later store-exclusive from the same port is let through only if the reservation is still armed, names the same word and targets normal shareable memory. The block then raises the write enable for that port and returns status 0. Otherwise it withholds the write and returns status 1.

A reservation is dropped for several reasons. The owner takes or returns from an exception. The owner issues a clear-exclusive command. The owner issues any store-exclusive, whether it succeeds or not. Another port writes to the reserved word. When several ports store to one word in the same cycle, the lowest-numbered eligible port wins. All outputs are registered and appear on the cycle after the request. The memory array itself and the memory-attribute decoding are outside the block; a single per-port flag marks the access as normal shareable memory.

Top module: `excl_monitor`

## Requirements
- R1: Each port's request operation is a 2-bit field: 00 is a plain write, 01 a load-exclusive, 10 a store-exclusive and 11 a clear-exclusive. A load-exclusive arms that port's reservation for the word addressed.
- R2: A store-exclusive from a port with an armed reservation for the same word, flagged normal, and not beaten by a conflict, raises that port's `wr_en_o` and returns `status_o` = 0 with `status_valid_o` high.
- R3: A store-exclusive that does not meet R2 leaves `wr_en_o` low and returns `status_o` = 1 with `status_valid_o` high.
- R4: Any store-exclusive, whether it succeeds or fails, disarms the issuing port's reservation. A clear-exclusive command also disarms it.
- R5: Exception entry or return on a port (`exc_event_i`) disarms that port's reservation. This takes priority over a load-exclusive from that port in the same cycle.
- R6: A plain write or a successful store-exclusive from another port to the reserved word disarms the reservation. A plain write from the owning port does not disarm it.
- R7: A store-exclusive with `req_normal_i` low always fails and never writes.
- R8: Words are compared with address bits [1:0] ignored. A store-exclusive to a different word fails, and it still disarms the reservation.
- R9: When several ports issue eligible store-exclusives to one word in the same cycle, only the lowest-numbered port succeeds. The others get status 1.
- R10: A plain write from another port to the same word in the same cycle makes a store-exclusive fail.
- R11: A new load-exclusive replaces the port's earlier reservation. After it, only the new word can succeed.
- R12: Synchronous reset disarms every reservation and clears all outputs. `wr_en_o` and `status_valid_o` follow a request by exactly one cycle. `status_valid_o` stays low for operations other than store-exclusive, and a plain write raises `wr_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | N_PORTS | Request present, one bit per port |
| req_op_i | input | 2*N_PORTS | Operation code per port (R1 encoding), port p at bits [2p+1:2p] |
| req_addr_i | input | N_PORTS*ADDR_W | Byte address per port, port p at bits [p*ADDR_W +: ADDR_W] |
| req_normal_i | input | N_PORTS | Access targets normal shareable memory |
| exc_event_i | input | N_PORTS | Exception entry or return on the port |
| wr_en_o | output | N_PORTS | Memory write allowed for the previous cycle's request |
| status_valid_o | output | N_PORTS | Store-exclusive status present |
| status_o | output | N_PORTS | 0 = store-exclusive succeeded, 1 = failed |

## Verification
The reservation bits and word tags are not visible at the ports. A corrupted bit or tag therefore shows up only when the owning port next issues a store-exclusive. One cycle after that request, `wr_en_o` and `status_o` give the wrong answer. A missed snoop clear, or a reservation that was never armed, shows up as a spurious success or a spurious failure at that point. The bench therefore follows every load-exclusive with store-exclusives at varied distances and with interleaved traffic from the other ports. A reference model predicts each port's outputs one cycle after every request.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_LDEX  = 2'b01,
    OP_STEX  = 2'b10,
    OP_CLREX = 2'b11
  } excl_op_e;

  localparam logic STAT_OK   = 1'b0;
  localparam logic STAT_FAIL = 1'b1;

endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16,
  parameter int IDX     = 0,
  localparam int TAG_W  = ADDR_W - 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_i,
  input  logic                        clr_i,
  input  logic                        exc_i,
  input  logic [ADDR_W-1:0]           ld_addr_i,
  input  logic [N_PORTS-1:0]          wr_strobe_i,
  input  logic [N_PORTS*ADDR_W-1:0]   wr_addr_i,
  output logic                        valid_o,
  output logic [TAG_W-1:0]            tag_o
);

  logic [N_PORTS-1:0] hit;
  logic               snoop_hit;

  // a write from any other port to the held word breaks the reservation
  for (genvar q = 0; q < N_PORTS; q++) begin : g_snoop
    if (q != IDX) begin : g_other
      assign hit[q] = wr_strobe_i[q] && (wr_addr_i[q*ADDR_W+2 +: TAG_W] == tag_o);
    end else begin : g_self
      assign hit[q] = 1'b0;
    end
  end

  assign snoop_hit = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (exc_i) begin
      valid_o <= 1'b0;
    end else if (ld_i) begin
      valid_o <= 1'b1;
      tag_o   <= ld_addr_i[ADDR_W-1:2];
    end else if (clr_i || snoop_hit) begin
      valid_o <= 1'b0;
    end
  end

  assert_exc_clears_R5: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> !valid_o);

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> !valid_o);

  assert_ld_arms_R1: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !exc_i) |=> (valid_o && tag_o == $past(ld_addr_i[ADDR_W-1:2])));

endmodule

// File: rtl/excl_grant.sv
module excl_grant #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16,
  localparam int TAG_W  = ADDR_W - 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS-1:0]          is_sx_i,
  input  logic [N_PORTS-1:0]          is_wr_i,
  input  logic [N_PORTS-1:0]          normal_i,
  input  logic [N_PORTS*ADDR_W-1:0]   addr_i,
  input  logic [N_PORTS-1:0]          resv_valid_i,
  input  logic [N_PORTS*TAG_W-1:0]    resv_tag_i,
  output logic [N_PORTS-1:0]          grant_o
);

  logic [TAG_W-1:0]   req_tag  [N_PORTS];
  logic [TAG_W-1:0]   held_tag [N_PORTS];
  logic [N_PORTS-1:0] eligible;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_unpack
    assign req_tag[p]  = addr_i[p*ADDR_W+2 +: TAG_W];
    assign held_tag[p] = resv_tag_i[p*TAG_W +: TAG_W];
    assign eligible[p] = is_sx_i[p] && resv_valid_i[p] && normal_i[p]
                         && (req_tag[p] == held_tag[p]);
  end

  // lower index wins among eligible stores; a plain write to the word beats all
  always_comb begin
    for (int p = 0; p < N_PORTS; p++) begin
      logic blocked;
      blocked = 1'b0;
      for (int q = 0; q < N_PORTS; q++) begin
        if (q != p && req_tag[q] == req_tag[p]) begin
          if (is_wr_i[q] || (q < p && eligible[q])) blocked = 1'b1;
        end
      end
      grant_o[p] = eligible[p] && !blocked;
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk_p
    for (genvar q = p + 1; q < N_PORTS; q++) begin : g_chk_q
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_o[p] && grant_o[q]) |-> (req_tag[p] != req_tag[q]));
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS-1:0]          req_valid_i,
  input  logic [2*N_PORTS-1:0]        req_op_i,
  input  logic [N_PORTS*ADDR_W-1:0]   req_addr_i,
  input  logic [N_PORTS-1:0]          req_normal_i,
  input  logic [N_PORTS-1:0]          exc_event_i,
  output logic [N_PORTS-1:0]          wr_en_o,
  output logic [N_PORTS-1:0]          status_valid_o,
  output logic [N_PORTS-1:0]          status_o
);

  localparam int TAG_W = ADDR_W - 2;

  excl_op_e             op [N_PORTS];
  logic [N_PORTS-1:0]   is_wr, is_ld, is_sx, is_clr;
  logic [N_PORTS-1:0]   grant, wr_strobe;
  logic [N_PORTS-1:0]   resv_valid;
  logic [N_PORTS*TAG_W-1:0] resv_tag;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign op[p]     = excl_op_e'(req_op_i[2*p +: 2]);
    assign is_wr[p]  = req_valid_i[p] && op[p] == OP_WRITE;
    assign is_ld[p]  = req_valid_i[p] && op[p] == OP_LDEX;
    assign is_sx[p]  = req_valid_i[p] && op[p] == OP_STEX;
    assign is_clr[p] = req_valid_i[p] && op[p] == OP_CLREX;

    excl_resv_slot #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .IDX(p)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .ld_i       (is_ld[p]),
      .clr_i      (is_sx[p] | is_clr[p]),
      .exc_i      (exc_event_i[p]),
      .ld_addr_i  (req_addr_i[p*ADDR_W +: ADDR_W]),
      .wr_strobe_i(wr_strobe),
      .wr_addr_i  (req_addr_i),
      .valid_o    (resv_valid[p]),
      .tag_o      (resv_tag[p*TAG_W +: TAG_W])
    );
  end

  excl_grant #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_grant (
    .clk         (clk),
    .rst         (rst),
    .is_sx_i     (is_sx),
    .is_wr_i     (is_wr),
    .normal_i    (req_normal_i),
    .addr_i      (req_addr_i),
    .resv_valid_i(resv_valid),
    .resv_tag_i  (resv_tag),
    .grant_o     (grant)
  );

  assign wr_strobe = is_wr | grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o        <= '0;
      status_valid_o <= '0;
      status_o       <= '0;
    end else begin
      wr_en_o        <= wr_strobe;
      status_valid_o <= is_sx;
      for (int p = 0; p < N_PORTS; p++)
        status_o[p] <= grant[p] ? STAT_OK : STAT_FAIL;
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_assert
    assert_ok_needs_resv_R2: assert property (@(posedge clk) disable iff (rst)
      (status_valid_o[p] && status_o[p] == STAT_OK) |-> $past(resv_valid[p]));

    assert_fail_no_write_R3: assert property (@(posedge clk) disable iff (rst)
      (status_valid_o[p] && status_o[p] == STAT_FAIL) |-> !wr_en_o[p]);

    assert_nonnormal_fails_R7: assert property (@(posedge clk) disable iff (rst)
      (is_sx[p] && !req_normal_i[p]) |=> (status_o[p] == STAT_FAIL && !wr_en_o[p]));

    assert_status_timing_R12: assert property (@(posedge clk) disable iff (rst)
      is_sx[p] |=> status_valid_o[p]);

    assert_no_status_other_R12: assert property (@(posedge clk) disable iff (rst)
      !is_sx[p] |=> !status_valid_o[p]);

    assert_sx_disarms_R4: assert property (@(posedge clk) disable iff (rst)
      (is_sx[p] && !is_ld[p]) |=> !resv_valid[p]);
  end

endmodule

// File: tb/test_excl_monitor.sv
`timescale 1ns/1ps
module test_excl_monitor;

  localparam int N  = 3;
  localparam int AW = 16;
  localparam int TW = AW - 2;
  localparam logic [1:0] OPW = 2'b00, OPL = 2'b01, OPS = 2'b10, OPC = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    req_normal = '0;
  logic [N-1:0]    exc_event = '0;
  logic [N-1:0]    wr_en, status_valid, status;

  always #2.5 clk = ~clk;

  excl_monitor #(.N_PORTS(N), .ADDR_W(AW)) i_excl_monitor (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_normal_i(req_normal), .exc_event_i(exc_event),
    .wr_en_o(wr_en), .status_valid_o(status_valid), .status_o(status)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R12";

  // per-port stimulus for the next step
  logic          s_v [N];
  logic [1:0]    s_op[N];
  logic [AW-1:0] s_a [N];
  logic          s_n [N];
  logic          s_x [N];

  // reference reservation state
  logic          m_v [N];
  logic [TW-1:0] m_t [N];

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic logic [TW-1:0] tg(input logic [AW-1:0] a);
    return a[AW-1:2];
  endfunction

  task automatic idle_all();
    for (int p = 0; p < N; p++) begin
      s_v[p] = 0; s_op[p] = OPW; s_a[p] = '0; s_n[p] = 1; s_x[p] = 0;
    end
  endtask

  task automatic set(input int p, input logic [1:0] op, input logic [AW-1:0] a);
    s_v[p] = 1; s_op[p] = op; s_a[p] = a;
  endtask

  task automatic step();
    logic raw [N];
    logic grt [N];
    logic ewr [N];
    logic esv [N];
    logic nv  [N];
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      req_valid[p] = s_v[p];
      req_op[2*p +: 2] = s_op[p];
      req_addr[p*AW +: AW] = s_a[p];
      req_normal[p] = s_n[p];
      exc_event[p] = s_x[p];
    end
    for (int p = 0; p < N; p++)
      raw[p] = s_v[p] && s_op[p] == OPS && m_v[p] && s_n[p] && tg(s_a[p]) == m_t[p];
    for (int p = 0; p < N; p++) begin
      logic blk;
      blk = 0;
      for (int q = 0; q < N; q++)
        if (q != p && s_v[q] && tg(s_a[q]) == tg(s_a[p]) &&
            (s_op[q] == OPW || (q < p && raw[q]))) blk = 1;
      grt[p] = raw[p] && !blk;
    end
    for (int p = 0; p < N; p++) begin
      ewr[p] = (s_v[p] && s_op[p] == OPW) || grt[p];
      esv[p] = s_v[p] && s_op[p] == OPS;
    end
    for (int p = 0; p < N; p++) begin
      logic hit;
      hit = 0;
      for (int q = 0; q < N; q++)
        if (q != p && ewr[q] && tg(s_a[q]) == m_t[p]) hit = 1;
      nv[p] = m_v[p];
      if (s_x[p]) nv[p] = 0;
      else if (s_v[p] && s_op[p] == OPL) begin nv[p] = 1; m_t[p] = tg(s_a[p]); end
      else if (s_v[p] && (s_op[p] == OPS || s_op[p] == OPC)) nv[p] = 0;
      else if (hit) nv[p] = 0;
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < N; p++) begin
      chk(wr_en[p], ewr[p], $sformatf("wr_en[%0d]", p));
      chk(status_valid[p], esv[p], $sformatf("status_valid[%0d]", p));
      if (esv[p]) chk(status[p], !grt[p], $sformatf("status[%0d]", p));
      m_v[p] = nv[p];
    end
    idle_all();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_all();
    for (int p = 0; p < N; p++) begin m_v[p] = 0; m_t[p] = '0; end
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R12";
    for (int p = 0; p < N; p++) begin
      chk(wr_en[p], 1'b0, "reset wr_en");
      chk(status_valid[p], 1'b0, "reset status_valid");
    end
    @(negedge clk); rst = 1'b0;

    cur_req = "R12"; set(0, OPS, 16'h0100); step();          // nothing armed after reset
    set(1, OPW, 16'h0040); step();                           // plain write passes, no status
    cur_req = "R1"; set(0, OPL, 16'h0100); step();
    cur_req = "R2"; set(0, OPS, 16'h0100); step();
    cur_req = "R4"; set(0, OPS, 16'h0100); step();           // second store fails
    set(0, OPL, 16'h0100); step(); set(0, OPC, 16'h0); step();
    set(0, OPS, 16'h0100); step();
    cur_req = "R5"; set(1, OPL, 16'h0180); step(); s_x[1] = 1; step();
    set(1, OPS, 16'h0180); step();
    set(1, OPL, 16'h0180); s_x[1] = 1; step(); set(1, OPS, 16'h0180); step();
    cur_req = "R6"; set(0, OPL, 16'h0200); step(); set(1, OPW, 16'h0202); step();
    set(0, OPS, 16'h0200); step();
    set(0, OPL, 16'h0200); step(); set(0, OPW, 16'h0200); step();
    set(2, OPW, 16'h0204); step(); set(0, OPS, 16'h0200); step();
    cur_req = "R7"; set(2, OPL, 16'h0280); step();
    set(2, OPS, 16'h0280); s_n[2] = 0; step();
    cur_req = "R8"; set(0, OPL, 16'h0300); step(); set(0, OPS, 16'h0303); step();
    set(0, OPL, 16'h0300); step(); set(0, OPS, 16'h0304); step();
    set(0, OPS, 16'h0300); step();
    cur_req = "R9";
    for (int p = 0; p < N; p++) set(p, OPL, 16'h0400);
    step();
    for (int p = 0; p < N; p++) set(p, OPS, 16'h0400);
    step();
    set(1, OPL, 16'h0440); set(2, OPL, 16'h0440); step();
    set(1, OPS, 16'h0440); set(2, OPS, 16'h0441); step();
    cur_req = "R10"; set(1, OPL, 16'h0500); step();
    set(1, OPS, 16'h0500); set(2, OPW, 16'h0500); step();
    cur_req = "R11"; set(2, OPL, 16'h0600); step(); set(2, OPL, 16'h0700); step();
    set(2, OPS, 16'h0600); step();
    set(2, OPL, 16'h0600); step(); set(2, OPL, 16'h0700); step();
    set(2, OPS, 16'h0700); step();

    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < N; p++) begin
        s_v[p]  = ($urandom % 4) != 0;
        s_op[p] = 2'($urandom % 4);
        s_a[p]  = 16'h0800 + 16'(($urandom % 4) * 4) + 16'($urandom % 4);
        s_n[p]  = ($urandom % 8) != 0;
        s_x[p]  = ($urandom % 16) == 0;
      end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule